// File: doc/BRIEF.md
# TLB Entry High-Word Access Unit

This block stores the high words of a small unified translation lookaside buffer. Each entry holds a 22-bit page tag, a 3-bit page-size code, a valid flag, an endianness flag, a user-defined flag and a translation ID. Software reaches the array through a special-register port. A transfer acts only when the select code equals 0x1004. The entry it touches is given by an index value that comes from a separate index register.

Each access also moves an ID between the entry and a process-ID register that sits outside the block. A write stores the current process ID into the entry's translation-ID field. A read issued outside user mode returns the entry's translation ID through a one-cycle load strobe, and the owner of the process-ID register loads that value.

Alongside the port, a combinational lookup compares a virtual address against every valid entry. The size code of each entry sets which address bits take part. The lookup reports a hit flag and the lowest-numbered matching entry. The array has no tie to the block's asynchronous reset. Only the configuration clear input zeroes it.

Top module: `tlbhi_unit`

## Requirements
- R1: A write with `spr_wr`=1 and `spr_sel`=0x1004 updates entry `entry_idx` at the next rising edge. A write with any other select value changes no entry.
- R2: Field layout, given as conventional bit numbers of the 32-bit word: tag = [31:10], size code = [9:7], valid = [6], endian = [5], user-defined = [4], reserved = [3:0]. A selected read with `spr_rd`=1 makes `spr_rdata` show the entry word one cycle later. Its reserved bits read 0 whatever value was written to them.
- R3: A selected write stores `pid_cur` into the entry's translation-ID field.
- R4: A selected read with `user_mode`=0 pulses `pid_load` in the same cycle that the data appears, with `pid_load_val` equal to the entry's translation ID. With `user_mode`=1, `pid_load` stays 0.
- R5: A read that is not selected, or a cycle with no read, gives `spr_rdata`=0 and `pid_load`=0 in the following cycle.
- R6: Asserting `rst_n` leaves every entry unchanged, and it clears only `spr_rdata` and `pid_load`. A cycle with `array_clear`=1 sets every entry, including its translation ID, to zero.
- R7: An entry with size code s covers a page of 2^(10+2s) bytes. The entry matches when `lk_addr`[31:10+2s] equals the corresponding tag bits. Address bits below 10+2s are ignored.
- R8: An entry whose valid flag is 0 never produces a hit.
- R9: A hit also needs the entry's translation ID to equal `pid_cur`, or to be zero.
- R10: When several entries match, `lk_hit`=1 and `lk_idx` gives the lowest-numbered one. When no entry matches, `lk_hit`=0.
- R11: With parameter READ_EN=0, a selected read returns 0 and never pulses `pid_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset for the port registers only |
| array_clear | input | 1 | Configuration-time clear of the whole array |
| spr_sel | input | 14 | Special-register select code |
| spr_wr | input | 1 | Special-register write strobe |
| spr_rd | input | 1 | Special-register read strobe |
| spr_wdata | input | 32 | Write data |
| spr_rdata | output | 32 | Read data, one cycle after the read |
| entry_idx | input | IDX_W | Entry number from the index register |
| pid_cur | input | TID_W | Current process ID |
| user_mode | input | 1 | User-mode flag from the status register |
| pid_load | output | 1 | Load strobe for the process-ID register |
| pid_load_val | output | TID_W | Translation ID to be loaded |
| lk_addr | input | 32 | Virtual address to look up |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Lowest-numbered matching entry |

## Verification
A corrupted tag, size code or flag in the array shows up in `spr_rdata` one cycle after a read of that entry. It shows up in `lk_hit` at once, because the lookup path has no register. Each size code is tested by flipping every address bit in turn, so a mask boundary that is off by even one bit changes the hit result for a known bit. A translation ID that was stored wrongly shows in `pid_load_val` on the next read outside user mode. It also shows as a wrong hit or miss when the process ID differs from it.

// File: rtl/tlbhi_pkg.sv
package tlbhi_pkg;

  localparam int unsigned TAG_W  = 22;
  localparam int unsigned SIZE_W = 3;
  localparam int unsigned MIN_PG = 10;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [SIZE_W-1:0] size;
    logic              v;
    logic              e;
    logic              u0;
  } hi_word_t;

  function automatic logic [31:0] pack_word(hi_word_t w);
    return {w.tag, w.size, w.v, w.e, w.u0, 4'b0000};
  endfunction

  function automatic hi_word_t unpack_word(logic [31:0] d);
    hi_word_t w;
    w.tag  = d[31:10];
    w.size = d[9:7];
    w.v    = d[6];
    w.e    = d[5];
    w.u0   = d[4];
    return w;
  endfunction

endpackage

// File: rtl/tlbhi_store.sv
module tlbhi_store
  import tlbhi_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 64,
  parameter int unsigned TID_W     = 8,
  localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  hi_word_t         wword,
  input  logic [TID_W-1:0] wtid,
  input  logic [IDX_W-1:0] ridx,
  output hi_word_t         rword,
  output logic [TID_W-1:0] rtid,
  output hi_word_t         ent_o [N_ENTRIES],
  output logic [TID_W-1:0] tid_o [N_ENTRIES]
);

  hi_word_t         ent_q [N_ENTRIES];
  logic [TID_W-1:0] tid_q [N_ENTRIES];

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    hi_word_t         ent_d;
    logic [TID_W-1:0] tid_d;
    logic             ld;

    always_comb begin
      ld    = clr | (we & (widx == IDX_W'(i)));
      ent_d = clr ? '0 : wword;
      tid_d = clr ? '0 : wtid;
    end

    always_ff @(posedge clk) begin
      if (ld) begin
        ent_q[i] <= ent_d;
        tid_q[i] <= tid_d;
      end
    end

    assign ent_o[i] = ent_q[i];
    assign tid_o[i] = tid_q[i];
  end

  always_comb begin
    rword = ent_q[ridx];
    rtid  = tid_q[ridx];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr) |=> (ent_q[$past(widx)] == $past(wword) && tid_q[$past(widx)] == $past(wtid))); // R1
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ent_q[0] == '0 && tid_q[N_ENTRIES-1] == '0)); // R6

endmodule

// File: rtl/tlbhi_match.sv
module tlbhi_match
  import tlbhi_pkg::*;
#(
  parameter int unsigned TID_W = 8
) (
  input  hi_word_t         ent,
  input  logic [TID_W-1:0] tid,
  input  logic [31:0]      addr,
  input  logic [TID_W-1:0] pid,
  output logic             m
);

  logic [TAG_W-1:0] keep;
  logic [TAG_W-1:0] diff;
  logic             tag_eq;
  logic             id_ok;

  always_comb begin
    for (int b = 0; b < int'(TAG_W); b++) begin
      keep[b] = (b >= 2 * int'(ent.size));
    end
    diff   = (addr[31:MIN_PG] ^ ent.tag) & keep;
    tag_eq = (diff == '0);
    id_ok  = (tid == '0) | (tid == pid);
    m      = ent.v & tag_eq & id_ok;
  end

endmodule

// File: rtl/tlbhi_prio.sv
module tlbhi_prio #(
  parameter int unsigned N_ENTRIES = 64,
  localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_ENTRIES-1:0] m,
  output logic                 hit,
  output logic [IDX_W-1:0]     idx
);

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = int'(N_ENTRIES) - 1; i >= 0; i--) begin
      if (m[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  AST_HIT_IS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> m[idx]); // R10
  AST_MISS_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (m == '0)); // R10

endmodule

// File: rtl/tlbhi_spr.sv
module tlbhi_spr
  import tlbhi_pkg::*;
#(
  parameter int unsigned     SEL_W    = 14,
  parameter logic [SEL_W-1:0] SEL_CODE = 14'h1004,
  parameter bit              READ_EN  = 1'b1,
  parameter int unsigned     TID_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             wr,
  input  logic             rd,
  input  logic [31:0]      wdata,
  input  logic             user_mode,
  input  hi_word_t         rd_word,
  input  logic [TID_W-1:0] rd_tid,
  output logic             we,
  output hi_word_t         wword,
  output logic [31:0]      rdata,
  output logic             pid_load,
  output logic [TID_W-1:0] pid_load_val
);

  logic             hit_sel;
  logic             rd_act;
  logic [31:0]      rdata_d;
  logic             pld_d;
  logic [TID_W-1:0] pval_d;
  logic [31:0]      rdata_q;
  logic             pld_q;
  logic [TID_W-1:0] pval_q;

  always_comb begin
    hit_sel = (sel == SEL_CODE);
    we      = wr & hit_sel;
    wword   = unpack_word(wdata);
    rd_act  = rd & hit_sel & READ_EN;
    rdata_d = rd_act ? pack_word(rd_word) : '0;
    pld_d   = rd_act & ~user_mode;
    pval_d  = pld_d ? rd_tid : pval_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      pld_q   <= 1'b0;
      pval_q  <= '0;
    end else begin
      rdata_q <= rdata_d;
      pld_q   <= pld_d;
      pval_q  <= pval_d;
    end
  end

  assign rdata        = rdata_q;
  assign pid_load     = pld_q;
  assign pid_load_val = pval_q;

  AST_UNSEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && sel == SEL_CODE) |=> (rdata == '0 && !pid_load)); // R5
  AST_USER_KEEPS_PID: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && user_mode) |=> !pid_load); // R4
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[3:0] == 4'b0000); // R2
  if (!READ_EN) begin : g_noread_chk
    AST_NOREAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> (rdata == '0 && !pid_load)); // R11
  end

endmodule

// File: rtl/tlbhi_unit.sv
module tlbhi_unit
  import tlbhi_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 64,
  parameter int unsigned TID_W     = 8,
  parameter bit          READ_EN   = 1'b1,
  localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             array_clear,
  input  logic [13:0]      spr_sel,
  input  logic             spr_wr,
  input  logic             spr_rd,
  input  logic [31:0]      spr_wdata,
  output logic [31:0]      spr_rdata,
  input  logic [IDX_W-1:0] entry_idx,
  input  logic [TID_W-1:0] pid_cur,
  input  logic             user_mode,
  output logic             pid_load,
  output logic [TID_W-1:0] pid_load_val,
  input  logic [31:0]      lk_addr,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx
);

  logic             we;
  hi_word_t         wword;
  hi_word_t         rword;
  logic [TID_W-1:0] rtid;
  hi_word_t         ent [N_ENTRIES];
  logic [TID_W-1:0] tid [N_ENTRIES];
  logic [N_ENTRIES-1:0] mvec;

  tlbhi_spr #(
    .SEL_W(14), .SEL_CODE(14'h1004), .READ_EN(READ_EN), .TID_W(TID_W)
  ) u_spr (
    .clk(clk), .rst_n(rst_n), .sel(spr_sel), .wr(spr_wr), .rd(spr_rd),
    .wdata(spr_wdata), .user_mode(user_mode), .rd_word(rword), .rd_tid(rtid),
    .we(we), .wword(wword), .rdata(spr_rdata), .pid_load(pid_load),
    .pid_load_val(pid_load_val)
  );

  tlbhi_store #(.N_ENTRIES(N_ENTRIES), .TID_W(TID_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(array_clear), .we(we), .widx(entry_idx),
    .wword(wword), .wtid(pid_cur), .ridx(entry_idx), .rword(rword), .rtid(rtid),
    .ent_o(ent), .tid_o(tid)
  );

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_match
    tlbhi_match #(.TID_W(TID_W)) u_match (
      .ent(ent[i]), .tid(tid[i]), .addr(lk_addr), .pid(pid_cur), .m(mvec[i])
    );
  end

  tlbhi_prio #(.N_ENTRIES(N_ENTRIES)) u_prio (
    .clk(clk), .rst_n(rst_n), .m(mvec), .hit(lk_hit), .idx(lk_idx)
  );

  AST_NO_INVALID_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ent[lk_idx].v); // R8
  AST_TID_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (tid[lk_idx] == '0 || tid[lk_idx] == pid_cur)); // R9

endmodule

// File: tb/tlbhi_unit_test.sv
`timescale 1ns/1ps
module tlbhi_unit_test;

  localparam int N  = 8;
  localparam int IW = 3;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic array_clear = 1'b0;
  logic [13:0] spr_sel = '0;
  logic spr_wr = 1'b0, spr_rd = 1'b0;
  logic [31:0] spr_wdata = '0;
  logic [IW-1:0] entry_idx = '0;
  logic [TW-1:0] pid_cur = '0;
  logic user_mode = 1'b0;
  logic [31:0] lk_addr = '0;
  logic [31:0] spr_rdata, rdata_nr;
  logic pid_load, pload_nr, lk_hit, hit_nr;
  logic [TW-1:0] pid_load_val, pval_nr;
  logic [IW-1:0] lk_idx, lidx_nr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] exp_w [N];
  logic [TW-1:0] exp_t [N];

  always #2.5 clk = ~clk;

  tlbhi_unit #(.N_ENTRIES(N), .TID_W(TW), .READ_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .array_clear(array_clear), .spr_sel(spr_sel),
    .spr_wr(spr_wr), .spr_rd(spr_rd), .spr_wdata(spr_wdata), .spr_rdata(spr_rdata),
    .entry_idx(entry_idx), .pid_cur(pid_cur), .user_mode(user_mode),
    .pid_load(pid_load), .pid_load_val(pid_load_val), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_idx(lk_idx)
  );

  tlbhi_unit #(.N_ENTRIES(N), .TID_W(TW), .READ_EN(1'b0)) uut_nr (
    .clk(clk), .rst_n(rst_n), .array_clear(array_clear), .spr_sel(spr_sel),
    .spr_wr(spr_wr), .spr_rd(spr_rd), .spr_wdata(spr_wdata), .spr_rdata(rdata_nr),
    .entry_idx(entry_idx), .pid_cur(pid_cur), .user_mode(user_mode),
    .pid_load(pload_nr), .pid_load_val(pval_nr), .lk_addr(lk_addr),
    .lk_hit(hit_nr), .lk_idx(lidx_nr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d, input logic [TW-1:0] pid, input logic [13:0] sel);
    @(negedge clk);
    spr_sel = sel; spr_wr = 1'b1; spr_wdata = d; entry_idx = IW'(idx); pid_cur = pid;
    @(negedge clk);
    spr_wr = 1'b0;
    if (sel == 14'h1004) begin
      exp_w[idx] = d & 32'hFFFF_FFF0;
      exp_t[idx] = pid;
    end
  endtask

  task automatic rd(input int idx, input bit um, input logic [13:0] sel);
    @(negedge clk);
    spr_sel = sel; spr_rd = 1'b1; entry_idx = IW'(idx); user_mode = um;
    @(negedge clk);
    spr_rd = 1'b0;
  endtask

  function automatic bit exp_match(input int i, input logic [31:0] a, input logic [TW-1:0] p);
    int pb;
    pb = 10 + 2 * int'(exp_w[i][9:7]);
    return exp_w[i][6] && ((a >> pb) == (exp_w[i] >> pb)) && (exp_t[i] == 0 || exp_t[i] == p);
  endfunction

  task automatic look(input logic [31:0] a, input logic [TW-1:0] p, input string req);
    bit eh;
    int ei;
    @(negedge clk);
    lk_addr = a; pid_cur = p;
    #1;
    eh = 1'b0; ei = 0;
    for (int i = N - 1; i >= 0; i--) if (exp_match(i, a, p)) begin eh = 1'b1; ei = i; end
    chk(lk_hit == eh, req, {31'd0, lk_hit}, {31'd0, eh});
    if (eh) chk(lk_idx == IW'(ei), req, {29'd0, lk_idx}, ei);
  endtask

  task automatic clear_all;
    @(negedge clk); array_clear = 1'b1;
    @(negedge clk); array_clear = 1'b0;
    for (int i = 0; i < N; i++) begin exp_w[i] = '0; exp_t[i] = '0; end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL R1 actual=timeout expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    array_clear = 1'b1;
    @(negedge clk); array_clear = 1'b0;
    for (int i = 0; i < N; i++) begin exp_w[i] = '0; exp_t[i] = '0; end
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(spr_rdata == 0, "R6 reset rdata", spr_rdata, 0);
    chk(!pid_load, "R6 reset pid_load", {31'd0, pid_load}, 0);
    look(32'h0, 8'h00, "R8 cleared array no hit");

    // R1 R2 R3 write and read back every entry
    for (int i = 0; i < N; i++)
      wr(i, 32'hA5C3_9E0F ^ (32'h1357_9BDF * i), TW'(8'h10 + i), 14'h1004);
    for (int i = 0; i < N; i++) begin
      rd(i, 1'b0, 14'h1004);
      chk(spr_rdata == exp_w[i], "R2 readback", spr_rdata, exp_w[i]);
      chk(spr_rdata[3:0] == 0, "R2 reserved zero", spr_rdata, exp_w[i]);
      chk(pid_load && pid_load_val == exp_t[i], "R3 R4 tid to pid", {23'd0, pid_load, pid_load_val}, {23'd1, exp_t[i]});
      chk(rdata_nr == 0 && !pload_nr, "R11 read disabled", rdata_nr, 0);
      @(negedge clk);
      chk(spr_rdata == 0 && !pid_load, "R5 idle cycle", spr_rdata, 0);
    end

    // R4 user mode
    rd(3, 1'b1, 14'h1004);
    chk(!pid_load, "R4 user mode no load", {31'd0, pid_load}, 0);
    chk(spr_rdata == exp_w[3], "R4 user mode data", spr_rdata, exp_w[3]);

    // R5 unselected read, R1 unselected writes
    rd(2, 1'b0, 14'h1005);
    chk(spr_rdata == 0 && !pid_load, "R5 unselected read", spr_rdata, 0);
    wr(2, 32'hFFFF_FFFF, 8'hEE, 14'h1005);
    wr(2, 32'h0000_0000, 8'hEE, 14'h0004);
    rd(2, 1'b0, 14'h1004);
    chk(spr_rdata == exp_w[2], "R1 unselected write ignored", spr_rdata, exp_w[2]);
    chk(pid_load_val == exp_t[2], "R1 tid kept", pid_load_val, exp_t[2]);

    // R6 reset keeps array
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(spr_rdata == 0, "R6 rdata in reset", spr_rdata, 0);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin
      rd(i, 1'b0, 14'h1004);
      chk(spr_rdata == exp_w[i], "R6 array survives reset", spr_rdata, exp_w[i]);
    end

    // R7 size sweep, single-bit flips
    for (int s = 0; s < 8; s++) begin
      clear_all();
      wr(0, (32'hC6A5_3000 & 32'hFFFF_FC00) | (s << 7) | 32'h40, 8'h00, 14'h1004);
      for (int b = 0; b < 32; b++)
        look(exp_w[0] ^ (32'd1 << b), 8'h5A, "R7 size compare");
      look(exp_w[0], 8'h5A, "R7 exact address");
    end

    // R8 invalid entry
    clear_all();
    wr(1, 32'h1234_5400, 8'h00, 14'h1004);
    look(32'h1234_5400, 8'h00, "R8 invalid no hit");

    // R9 translation ID
    wr(1, 32'h1234_5440, 8'h07, 14'h1004);
    look(32'h1234_5400, 8'h07, "R9 tid equal");
    look(32'h1234_5400, 8'h03, "R9 tid differs");
    wr(4, 32'h1234_5440, 8'h00, 14'h1004);
    look(32'h1234_5400, 8'h03, "R9 tid zero global");

    // R10 priority
    wr(2, 32'h1234_5440, 8'h00, 14'h1004);
    look(32'h1234_5400, 8'h07, "R10 lowest index");
    look(32'h1234_5400, 8'h03, "R10 skip tid miss");
    wr(1, 32'h1234_5400, 8'h07, 14'h1004);
    wr(2, 32'h1234_5400, 8'h00, 14'h1004);
    look(32'h1234_5400, 8'h03, "R10 next after invalidate");

    // R6 clear zeroes tid too
    clear_all();
    for (int i = 0; i < N; i++) begin
      rd(i, 1'b0, 14'h1004);
      chk(spr_rdata == 0 && pid_load_val == 0, "R6 clear zeroes", {spr_rdata[31:8], pid_load_val}, 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule